// File: doc/BRIEF.md
# Two-Bank Frame Handoff Controller

This block arbitrates two external frame stores between a frame producer (for example a capture stage) and a frame consumer (for example a neighbourhood-window builder feeding a filter). The producer always fills one store while the consumer may read the other, so that capture of frame N+1 overlaps processing of frame N. The block holds no pixels. It tracks which store each side owns, gives each side a bank-select, and flags when a fully written frame waits to be read.

Ownership changes only at frame boundaries. The producer reports the start and the end of each frame. At the end it moves to the other store, unless the consumer is holding that store. In that case it stays where it is and overwrites its own frame on the next pass, and the lost frame is counted. The consumer may claim a frame only when one is marked complete in the store the producer does not own. Claiming the frame clears its mark, and the consumer keeps the store until it reports that it is done. Neither side can therefore see a partly written frame.

Top module: `pp_frame_ctrl`

## Requirements
- R1: After reset the producer owns bank 0 (`wr_bank`=0), `wr_busy`=0, `rd_busy`=0, `rd_ready`=0 and `drop_count`=0.
- R2: A `wr_done` pulse during a producer frame, while the consumer does not hold the other bank, toggles `wr_bank` on the next cycle and marks the just-finished bank complete, so `rd_ready` reads 1 while the consumer is idle. `wr_bank` never changes at any other time.
- R3: `wr_done` while `wr_busy`=0 has no effect. A `wr_start` while `wr_busy`=1 has no effect. `wr_start` while idle sets `wr_busy` on the next cycle, and an accepted `wr_done` clears it.
- R4: `rd_start` while `rd_ready`=1 sets `rd_busy` and points `rd_bank` at the non-producer bank on the next cycle. It clears that bank's complete mark. `rd_bank` holds until a `rd_done`.
- R5: `rd_start` while `rd_ready`=0 is ignored. `rd_done` while the consumer is idle is ignored.
- R6: If the producer finishes while the consumer holds the other bank, `wr_bank` stays unchanged, no bank is marked complete and `drop_count` increases by one.
- R7: If the producer moves onto a bank whose complete frame was never claimed, that stale frame is discarded: its mark is cleared, `drop_count` increases by one, and only the newest frame is marked complete.
- R8: When `rd_start` is granted in the same cycle as an accepted `wr_done`, the consumer wins and the producer follows R6.
- R9: When `rd_done` and an accepted `wr_done` fall in the same cycle, the bank is treated as released and the producer moves over as in R2.
- R10: `drop_count` is `CNT_W` bits wide (8 by default). It saturates at its maximum and never decreases outside reset.
- R11: While `rd_busy`=1, `rd_bank` is never equal to `wr_bank`. While the consumer is idle, `rd_bank` shows the bank it would get, which is the inverse of `wr_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_start | input | 1 | Producer begins a frame (one-cycle pulse) |
| wr_done | input | 1 | Producer finished its frame (one-cycle pulse) |
| rd_start | input | 1 | Consumer requests a complete frame (one-cycle pulse) |
| rd_done | input | 1 | Consumer releases its bank (one-cycle pulse) |
| wr_bank | output | 1 | Bank the producer writes |
| wr_busy | output | 1 | Producer frame in progress |
| rd_bank | output | 1 | Bank the consumer reads |
| rd_busy | output | 1 | Consumer holds a bank |
| rd_ready | output | 1 | A complete frame waits in the non-producer bank and the consumer is idle |
| drop_count | output | CNT_W | Saturating count of discarded frames |

## Verification
The assertions check on every cycle that the two sides never share a bank, that the producer's bank moves only after a frame end, that a held consumer bank stays put, that a refused hand-over leaves the producer in place, that a grant clears the ready flag and that the drop count never falls. The contested orderings need the bench's scenarios: simultaneous grant and frame end, simultaneous release and frame end, overwriting of an unclaimed frame, ignored pulses, and saturation of the counter after a long run of drops. A reference model in the bench predicts every output for each of these sequences.

// File: rtl/pp_pkg.sv
// Shared definitions for the two-bank frame handoff controller.
// Assumes exactly two banks; a bank id is therefore a single bit.
package pp_pkg;
    localparam int NUM_BANKS = 2;
    typedef logic bank_t;

    // Returns the bank that is not the one given.
    function automatic bank_t other_bank(input bank_t b);
        return ~b;
    endfunction
endpackage

// File: rtl/pp_wr_ctrl.sv
// Producer-side state: the bank being written and whether a frame is open.
// Assumes wr_start/wr_done are single-cycle pulses. A frame end moves the
// producer to the other bank unless the consumer holds it (rd_hold).
module pp_wr_ctrl
    import pp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_start,
    input  logic  wr_done,
    input  logic  rd_hold,
    output bank_t wr_bank,
    output logic  wr_busy,
    output logic  wr_fin,
    output logic  swap
);
    // A frame end counts only while a frame is open.
    assign wr_fin = wr_done & wr_busy;
    assign swap   = wr_fin & ~rd_hold;

    // Track whether the producer is inside a frame; the end has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        wr_busy <= 1'b0;
        else if (wr_fin)   wr_busy <= 1'b0;
        else if (wr_start) wr_busy <= 1'b1;
    end

    // Move the producer to the other bank on an allowed frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)    wr_bank <= 1'b0;
        else if (swap) wr_bank <= other_bank(wr_bank);
    end

    AST_BANK_MOVES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bank != $past(wr_bank)) |-> $past(wr_done)); // R2
endmodule

// File: rtl/pp_rd_ctrl.sv
// Consumer-side state: whether a bank is held and which one.
// Assumes rd_start/rd_done are single-cycle pulses. A start is granted only
// when the non-producer bank carries a complete frame (avail).
module pp_rd_ctrl
    import pp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_start,
    input  logic  rd_done,
    input  bank_t wr_bank,
    input  logic  avail,
    output logic  rd_busy,
    output bank_t rd_bank,
    output logic  rd_grant,
    output logic  rd_hold
);
    bank_t held_q;

    assign rd_grant = rd_start & ~rd_busy & avail;
    // Consumer blocks the other bank if it keeps it past this edge or takes it now.
    assign rd_hold  = (rd_busy & ~rd_done) | rd_grant;
    // While idle the select previews the bank a grant would give.
    assign rd_bank  = rd_busy ? held_q : other_bank(wr_bank);

    // Record hold status: granted start sets, done while busy clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_busy <= 1'b0;
        else if (rd_grant)          rd_busy <= 1'b1;
        else if (rd_busy & rd_done) rd_busy <= 1'b0;
    end

    // Latch the granted bank for the length of the read.
    always_ff @(posedge clk) begin
        if (!rst_n)        held_q <= 1'b1;
        else if (rd_grant) held_q <= other_bank(wr_bank);
    end

    AST_HELD_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && !rd_done) |=> (rd_busy && $stable(rd_bank))); // R4
endmodule

// File: rtl/pp_ready_flags.sv
// One "complete frame present" flag per bank.
// Assumes set and clear never target the same bank in one cycle; set wins.
module pp_ready_flags
    import pp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] set_vec,
    input  logic [NUM_BANKS-1:0] clr_vec,
    output logic [NUM_BANKS-1:0] ready_q
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flag
        // Hold the flag for bank b between completion and claim or overwrite.
        always_ff @(posedge clk) begin
            if (!rst_n)          ready_q[b] <= 1'b0;
            else if (set_vec[b]) ready_q[b] <= 1'b1;
            else if (clr_vec[b]) ready_q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/pp_drop_ctr.sv
// Saturating counter of discarded frames.
// Assumes at most one drop event per cycle.
module pp_drop_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up on each drop, stopping at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                         count <= '0;
        else if (inc && (count != CNT_MAX)) count <= count + 1'b1;
    end

    AST_DROP_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        count >= $past(count)); // R10
endmodule

// File: rtl/pp_frame_ctrl.sv
// Two-bank frame handoff controller (top).
// Producer fills one bank while the consumer reads the other. Ownership moves
// only at frame ends; a held consumer bank forces the producer to stay and
// drop. Assumes all handshake inputs are synchronous single-cycle pulses.
module pp_frame_ctrl
    import pp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic             wr_done,
    input  logic             rd_start,
    input  logic             rd_done,
    output logic             wr_bank,
    output logic             wr_busy,
    output logic             rd_bank,
    output logic             rd_busy,
    output logic             rd_ready,
    output logic [CNT_W-1:0] drop_count
);
    logic                 wr_fin, swap, rd_grant, rd_hold;
    logic                 avail, stale, drop_inc;
    logic [NUM_BANKS-1:0] set_vec, clr_vec, ready_q;
    bank_t                wb, rb;

    assign wr_bank = wb;
    assign rd_bank = rb;

    // A complete frame is offered from the bank the producer does not own.
    assign avail    = ready_q[other_bank(wb)];
    assign rd_ready = avail & ~rd_busy;
    // Moving onto an unclaimed frame discards it.
    assign stale    = swap & avail;
    assign drop_inc = (wr_fin & rd_hold) | stale;

    // Build per-bank set/clear requests for the complete flags.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            set_vec[b] = swap & (wb == bank_t'(b));
            clr_vec[b] = (rd_grant | swap) & (other_bank(wb) == bank_t'(b));
        end
    end

    pp_wr_ctrl u_wr (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_done(wr_done),
        .rd_hold(rd_hold), .wr_bank(wb), .wr_busy(wr_busy),
        .wr_fin(wr_fin), .swap(swap)
    );

    pp_rd_ctrl u_rd (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_done(rd_done),
        .wr_bank(wb), .avail(avail), .rd_busy(rd_busy), .rd_bank(rb),
        .rd_grant(rd_grant), .rd_hold(rd_hold)
    );

    pp_ready_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .ready_q(ready_q)
    );

    pp_drop_ctr #(.CNT_W(CNT_W)) u_drop (
        .clk(clk), .rst_n(rst_n), .inc(drop_inc), .count(drop_count)
    );

    AST_BANKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |-> (rd_bank != wr_bank)); // R11
    AST_GRANT_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |=> !rd_ready); // R4
    AST_REFUSED_END_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fin && rd_hold) |=> $stable(wr_bank)); // R6
    AST_IDLE_PREVIEW: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_busy |-> (rd_bank == !wr_bank)); // R11
endmodule

// File: tb/pp_frame_ctrl_tb.sv
// Scoreboard bench: the driver task applies one cycle of handshakes, advances
// a reference model written from the requirements and queues the expected
// outputs; the monitor samples shortly after each rising edge and compares.
module pp_frame_ctrl_tb;
    localparam int CNT_W = 8;
    localparam logic [CNT_W-1:0] MAXC = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_start = 0, wr_done = 0, rd_start = 0, rd_done = 0;
    logic wr_bank, wr_busy, rd_bank, rd_busy, rd_ready;
    logic [CNT_W-1:0] drop_count;

    int n_run = 0, n_fail = 0;

    typedef struct {
        logic wb, wbusy, rbank, rbusy, rrdy;
        logic [CNT_W-1:0] drop;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    // reference model state
    logic m_wb, m_wact, m_rbusy, m_rbank;
    logic [1:0] m_rdy;
    logic [CNT_W-1:0] m_drop;

    always #5 clk = ~clk;

    pp_frame_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_done(wr_done),
        .rd_start(rd_start), .rd_done(rd_done), .wr_bank(wr_bank),
        .wr_busy(wr_busy), .rd_bank(rd_bank), .rd_busy(rd_busy),
        .rd_ready(rd_ready), .drop_count(drop_count)
    );

    task automatic model_reset();
        m_wb = 0; m_wact = 0; m_rbusy = 0; m_rbank = 1; m_rdy = 2'b00; m_drop = '0;
    endtask

    task automatic push_exp(input string tag);
        exp_t e;
        e.wb = m_wb; e.wbusy = m_wact; e.rbusy = m_rbusy;
        e.rbank = m_rbusy ? m_rbank : !m_wb;
        e.rrdy = m_rdy[!m_wb] && !m_rbusy;
        e.drop = m_drop; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Driver: one cycle of stimulus plus model update and expectation.
    task automatic step(input logic ws, input logic wd, input logic rs,
                        input logic rdn, input string tag);
        logic grant, hold, fin, sw, drop;
        @(negedge clk);
        wr_start = ws; wr_done = wd; rd_start = rs; rd_done = rdn;
        grant = rs && !m_rbusy && m_rdy[!m_wb];
        hold  = (m_rbusy && !rdn) || grant;
        fin   = wd && m_wact;
        sw    = fin && !hold;
        drop  = (fin && hold) || (sw && m_rdy[!m_wb]);
        if (grant) begin
            m_rbank = !m_wb; m_rdy[!m_wb] = 0; m_rbusy = 1;
        end else if (m_rbusy && rdn) m_rbusy = 0;
        if (fin) m_wact = 0;
        else if (ws) m_wact = 1;
        if (sw) begin
            m_rdy[m_wb] = 1; m_rdy[!m_wb] = 0; m_wb = !m_wb;
        end
        if (drop && m_drop != MAXC) m_drop = m_drop + 1'b1;
        push_exp(tag);
    endtask

    // Monitor: compare just after each edge against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if (wr_bank !== e.wb || wr_busy !== e.wbusy || rd_busy !== e.rbusy ||
                    rd_bank !== e.rbank || rd_ready !== e.rrdy || drop_count !== e.drop) begin
                    n_fail++;
                    $display("FAIL %s: got wb=%b wbusy=%b rbusy=%b rbank=%b rdy=%b drop=%0d exp wb=%b wbusy=%b rbusy=%b rbank=%b rdy=%b drop=%0d",
                        e.tag, wr_bank, wr_busy, rd_busy, rd_bank, rd_ready, drop_count,
                        e.wb, e.wbusy, e.rbusy, e.rbank, e.rrdy, e.drop);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0,0,0,0, "R1 reset state");
        step(0,1,0,0, "R3 done without open frame");
        step(0,0,1,0, "R5 read start with nothing ready");
        step(0,0,0,1, "R5 read done while idle");
        step(1,0,0,0, "R3 producer start");
        step(1,0,0,0, "R3 repeated start ignored");
        step(0,1,0,0, "R2 frame end moves bank");
        step(0,0,1,0, "R4 consumer claims frame");
        step(1,0,1,0, "R4 start while busy changes nothing");
        step(0,1,0,0, "R6 producer blocked drops");
        step(0,0,0,1, "R4 consumer releases");
        step(1,0,0,0, "R2 next frame start");
        step(0,1,0,0, "R2 frame end after release");
        step(1,0,0,0, "R7 start over unread");
        step(0,1,0,0, "R7 stale frame discarded");
        step(1,0,0,0, "R8 start");
        step(0,1,1,0, "R8 grant beats frame end");
        step(1,0,0,0, "R9 start");
        step(0,1,0,1, "R9 release and end together");
        step(0,0,1,0, "R10 claim before drop run");
        for (int i = 0; i < 260; i++) begin
            step(1,0,0,0, "R10 drop run start");
            step(0,1,0,0, "R10 drop run end");
        end
        step(0,0,0,0, "R10 idle after saturation");
        @(negedge clk);
        wr_start = 0; wr_done = 0; rd_start = 0; rd_done = 0;
        @(negedge clk);
        n_run++;
        if (drop_count !== MAXC) begin
            n_fail++;
            $display("FAIL R10 saturation: got %0d exp %0d", drop_count, MAXC);
        end
        n_run++;
        if (rd_busy && (rd_bank === wr_bank)) begin
            n_fail++;
            $display("FAIL R11 shared bank: got rd_bank=%b exp not %b", rd_bank, wr_bank);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule